// File: doc/BRIEF.md
# Cycle-Stealing Memory Break Channel

This block gives up to four external devices direct access to core memory, one 18-bit word per stolen memory cycle, with no involvement of the running program. A device raises its request together with a transfer direction, a 15-bit word address and, for writes, an 18-bit data word. The channel waits for the current memory cycle to end and then takes the next cycle away from the processor. It drives the memory address and buffer lines for that cycle and answers the device with a short handshake.

The handshake has three strobes. The first accepts the address. The second confirms that write data has been taken. The third reports that read data is valid on the shared return bus. A memory cycle lasts a fixed number of clocks, counted by an internal phase counter, and every grant is aligned to the boundary between two cycles. While the channel owns a cycle, it holds the processor off. Memory is a synchronous RAM with a read latency of one clock.

Top module: `dbrk_channel`

## Requirements
- R1: While reset is held and in the first clock after reset, every strobe output, `cpu_hold`, `mem_we`, `mem_re` and `brk_rdata` are zero.
- R2: A stolen cycle starts only at a memory-cycle boundary. `cpu_hold` is high for exactly NPH clocks per granted request and is otherwise low.
- R3: `dev_addr_ack` pulses for one clock, in phase 0 of the stolen cycle, to the granted device only. Address and direction are captured at the grant edge, so changing the address after the pulse has no effect on the transfer.
- R4: For a write, the device data is sampled at the end of phase NPH/2-1 and written to memory in phase NPH/2. `dev_data_ack` then pulses in phase NPH/2+1.
- R5: For a read, `mem_re` is high in phase 0. `dev_data_rdy` pulses in phase NPH/2+1 with the word on `brk_rdata`, and `brk_rdata` keeps that word until the next read captures a new one.
- R6: Each stolen cycle moves exactly one word: one clock of either `mem_we` or `mem_re`, never both.
- R7: When several devices are pending at a boundary, the lowest-numbered device wins (device 0 highest).
- R8: A request seen for even one clock is remembered until that device is served.
- R9: A device that keeps its request high through its address-accepted pulse is served again in the very next memory cycle, NPH clocks later.
- R10: The direction is chosen per request: `dev_dir` = 1 writes memory, `dev_dir` = 0 reads memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_req | input | NDEV | Break request, one bit per device |
| dev_dir | input | NDEV | Direction per device: 1 into memory, 0 out of memory |
| dev_addr | input | NDEV*15 | Word address; device d in bits [d*15 +: 15] |
| dev_wdata | input | NDEV*18 | Write data; device d in bits [d*18 +: 18] |
| dev_addr_ack | output | NDEV | Address-accepted pulse per device |
| dev_data_ack | output | NDEV | Write-data-taken pulse per device |
| dev_data_rdy | output | NDEV | Read-data-valid pulse per device |
| brk_rdata | output | 18 | Word read from memory, shared by all devices |
| cpu_hold | output | 1 | Processor stall for the stolen cycle |
| mem_addr | output | 15 | Memory address during a stolen cycle |
| mem_wdata | output | 18 | Memory buffer write data |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable |
| mem_rdata | input | 18 | Memory read data, valid one clock after `mem_re` |

## Verification
The hardest situation to reach from the ports is a request that lasts one clock and falls inside a memory cycle, so that it is no longer asserted at any boundary. The stimulus lines up with phase 0 and raises the request only for the following clock.

Priority ordering is the other hard case. Three devices raise requests on the same clock, and one of them reads the address that a higher-priority device writes. The read result therefore shows which device was served first.

Back-to-back service is reached by holding the request high past the first address-accepted pulse while moving the address. The gap between the two pulses is then measured.

// File: rtl/dbrk_pkg.sv
package dbrk_pkg;

    localparam int BRK_AW     = 15;
    localparam int BRK_DW     = 18;
    localparam int BRK_MAXDEV = 4;
    localparam int BRK_IW     = $clog2(BRK_MAXDEV);

    typedef logic [BRK_IW-1:0] dev_idx_t;

    typedef enum logic {
        XFER_FROM_MEM = 1'b0,
        XFER_TO_MEM   = 1'b1
    } xfer_dir_e;

    typedef struct packed {
        dev_idx_t           dev;
        xfer_dir_e          dir;
        logic [BRK_AW-1:0]  addr;
    } slot_t;

    // lowest set bit wins
    function automatic dev_idx_t first_set(input logic [BRK_MAXDEV-1:0] v);
        dev_idx_t r;
        r = '0;
        for (int i = BRK_MAXDEV - 1; i >= 0; i--) begin
            if (v[i]) r = dev_idx_t'(i);
        end
        return r;
    endfunction

    function automatic logic [BRK_MAXDEV-1:0] idx_onehot(input dev_idx_t i);
        logic [BRK_MAXDEV-1:0] one;
        one = 1;
        return one << i;
    endfunction

endpackage

// File: rtl/dbrk_phase.sv
module dbrk_phase #(
    parameter int NPH = 4,
    localparam int PW = $clog2(NPH)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [PW-1:0] ph,
    output logic          last
);

    assign last = (ph == PW'(NPH - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            ph <= '0;
        end else if (last) begin
            ph <= '0;
        end else begin
            ph <= ph + 1'b1;
        end
    end

endmodule

// File: rtl/dbrk_arb.sv
module dbrk_arb
    import dbrk_pkg::*;
#(
    parameter int NDEV = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NDEV-1:0] req,
    input  logic            take,
    output logic            any,
    output dev_idx_t        win
);

    logic [NDEV-1:0]       pend;
    logic [NDEV-1:0]       cand;
    logic [NDEV-1:0]       clr;
    logic [BRK_MAXDEV-1:0] cand_w;

    assign cand = pend | req;
    assign any  = |cand;

    generate
        if (NDEV == BRK_MAXDEV) begin : g_full
            assign cand_w = cand;
        end else begin : g_pad
            assign cand_w = {{(BRK_MAXDEV - NDEV){1'b0}}, cand};
        end
    endgenerate

    assign win = first_set(cand_w);
    assign clr = take ? NDEV'(idx_onehot(win)) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
        end else begin
            pend <= cand & ~clr;
        end
    end

endmodule

// File: rtl/dbrk_xfer.sv
module dbrk_xfer
    import dbrk_pkg::*;
#(
    parameter int NDEV = 4,
    parameter int NPH  = 4,
    localparam int PW  = $clog2(NPH),
    localparam int MID = NPH / 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [PW-1:0]          ph,
    input  logic                   last,
    input  logic                   any,
    input  dev_idx_t               win,
    input  logic [NDEV-1:0]        dev_dir,
    input  logic [NDEV*BRK_AW-1:0] dev_addr,
    input  logic [NDEV*BRK_DW-1:0] dev_wdata,
    input  logic [BRK_DW-1:0]      mem_rdata,
    output logic [NDEV-1:0]        aack,
    output logic [NDEV-1:0]        dack,
    output logic [NDEV-1:0]        drdy,
    output logic [BRK_DW-1:0]      rdata,
    output logic                   hold,
    output logic [BRK_AW-1:0]      mem_addr,
    output logic [BRK_DW-1:0]      mem_wdata,
    output logic                   mem_we,
    output logic                   mem_re
);

    slot_t              cur;
    logic               active;
    logic [BRK_DW-1:0]  wbuf;
    logic [BRK_DW-1:0]  rbuf;
    xfer_dir_e          sel_dir;
    logic [BRK_AW-1:0]  sel_addr;
    logic [BRK_DW-1:0]  cur_wdata;
    logic [NDEV-1:0]    win_oh;
    logic [NDEV-1:0]    cur_oh;
    logic               grant;
    logic               at_sample;
    logic               at_mid;

    assign grant     = last & any;
    assign at_sample = active && (ph == PW'(MID - 1));
    assign at_mid    = active && (ph == PW'(MID));

    always_comb begin
        sel_dir   = xfer_dir_e'(dev_dir[win]);
        sel_addr  = dev_addr[int'(win) * BRK_AW +: BRK_AW];
        cur_wdata = dev_wdata[int'(cur.dev) * BRK_DW +: BRK_DW];
        win_oh    = NDEV'(idx_onehot(win));
        cur_oh    = NDEV'(idx_onehot(cur.dev));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cur    <= '0;
            wbuf   <= '0;
            rbuf   <= '0;
            aack   <= '0;
            dack   <= '0;
            drdy   <= '0;
        end else begin
            aack <= grant ? win_oh : '0;
            dack <= (at_mid && cur.dir == XFER_TO_MEM)   ? cur_oh : '0;
            drdy <= (at_mid && cur.dir == XFER_FROM_MEM) ? cur_oh : '0;
            if (last) begin
                active <= any;
                if (any) begin
                    cur <= '{dev: win, dir: sel_dir, addr: sel_addr};
                end
            end
            if (at_sample) begin
                if (cur.dir == XFER_TO_MEM) begin
                    wbuf <= cur_wdata;
                end else begin
                    rbuf <= mem_rdata;
                end
            end
        end
    end

    assign hold      = active;
    assign rdata     = rbuf;
    assign mem_addr  = active ? cur.addr : '0;
    assign mem_wdata = wbuf;
    assign mem_re    = active && (ph == '0) && (cur.dir == XFER_FROM_MEM);
    assign mem_we    = at_mid && (cur.dir == XFER_TO_MEM);

    AST_ONE_WORD: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re)) else $error("read and write in one clock"); // R6
    AST_STEAL_AT_EDGE: assert property (@(posedge clk) disable iff (rst)
        $rose(hold) |-> $past(last)) else $error("steal off boundary"); // R2
    AST_AACK_PHASE0: assert property (@(posedge clk) disable iff (rst)
        (|aack) |-> (hold && ph == '0)) else $error("address ack out of phase"); // R3
    AST_AACK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(aack)) else $error("address ack to several devices"); // R3
    AST_STROBE_PHASE: assert property (@(posedge clk) disable iff (rst)
        (|(dack | drdy)) |-> (hold && ph == PW'(MID + 1))) else $error("data strobe out of phase"); // R4
    AST_RDATA_HELD: assert property (@(posedge clk) disable iff (rst)
        (|drdy) |-> $stable(rdata)) else $error("read word moved under strobe"); // R5

endmodule

// File: rtl/dbrk_channel.sv
module dbrk_channel
    import dbrk_pkg::*;
#(
    parameter int NDEV = 4,
    parameter int NPH  = 4,
    localparam int PW  = $clog2(NPH)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NDEV-1:0]        dev_req,
    input  logic [NDEV-1:0]        dev_dir,
    input  logic [NDEV*BRK_AW-1:0] dev_addr,
    input  logic [NDEV*BRK_DW-1:0] dev_wdata,
    output logic [NDEV-1:0]        dev_addr_ack,
    output logic [NDEV-1:0]        dev_data_ack,
    output logic [NDEV-1:0]        dev_data_rdy,
    output logic [BRK_DW-1:0]      brk_rdata,
    output logic                   cpu_hold,
    output logic [BRK_AW-1:0]      mem_addr,
    output logic [BRK_DW-1:0]      mem_wdata,
    output logic                   mem_we,
    output logic                   mem_re,
    input  logic [BRK_DW-1:0]      mem_rdata
);

    logic [PW-1:0] ph;
    logic          last;
    logic          any;
    dev_idx_t      win;
    logic          take;

    assign take = last & any;

    dbrk_phase #(.NPH(NPH)) u_phase (
        .clk  (clk),
        .rst  (rst),
        .ph   (ph),
        .last (last)
    );

    dbrk_arb #(.NDEV(NDEV)) u_arb (
        .clk  (clk),
        .rst  (rst),
        .req  (dev_req),
        .take (take),
        .any  (any),
        .win  (win)
    );

    dbrk_xfer #(.NDEV(NDEV), .NPH(NPH)) u_xfer (
        .clk       (clk),
        .rst       (rst),
        .ph        (ph),
        .last      (last),
        .any       (any),
        .win       (win),
        .dev_dir   (dev_dir),
        .dev_addr  (dev_addr),
        .dev_wdata (dev_wdata),
        .mem_rdata (mem_rdata),
        .aack      (dev_addr_ack),
        .dack      (dev_data_ack),
        .drdy      (dev_data_rdy),
        .rdata     (brk_rdata),
        .hold      (cpu_hold),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_re    (mem_re)
    );

    AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
        (mem_we || mem_re) |-> cpu_hold) else $error("memory touched outside stolen cycle"); // R6
    AST_ACK_TO_REQUESTER: assert property (@(posedge clk) disable iff (rst)
        (|dev_addr_ack) |-> $past(cpu_hold) || $past(last)) else $error("ack without boundary"); // R2

endmodule

// File: tb/dbrk_channel_tb_top.sv
module dbrk_channel_tb_top;

    localparam int NDEV = 4;
    localparam int NPH  = 4;
    localparam int MID  = NPH / 2;
    localparam int AW   = 15;
    localparam int DW   = 18;

    typedef struct {
        int              dev;
        bit              wr;
        logic [AW-1:0]   addr;
        logic [DW-1:0]   data;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [NDEV-1:0]    t_req   = '0;
    logic [NDEV-1:0]    t_dir   = '0;
    logic [NDEV*AW-1:0] t_addr  = '0;
    logic [NDEV*DW-1:0] t_wdata = '0;

    logic [NDEV-1:0] aack, dack, drdy;
    logic [DW-1:0]   brk_rdata, mem_wdata, mem_rdata;
    logic [AW-1:0]   mem_addr;
    logic            cpu_hold, mem_we, mem_re;

    dbrk_channel #(.NDEV(NDEV), .NPH(NPH)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .dev_req      (t_req),
        .dev_dir      (t_dir),
        .dev_addr     (t_addr),
        .dev_wdata    (t_wdata),
        .dev_addr_ack (aack),
        .dev_data_ack (dack),
        .dev_data_rdy (drdy),
        .brk_rdata    (brk_rdata),
        .cpu_hold     (cpu_hold),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_we       (mem_we),
        .mem_re       (mem_re),
        .mem_rdata    (mem_rdata)
    );

    function automatic logic [DW-1:0] init_word(input int i);
        return DW'(i * 1237 + 341);
    endfunction

    // memory model
    logic [DW-1:0] ram [256];
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) ram[i] <= init_word(i);
            mem_rdata <= '0;
        end else begin
            if (mem_we) ram[mem_addr[7:0]] <= mem_wdata;
            if (mem_re) mem_rdata <= ram[mem_addr[7:0]];
        end
    end

    // cycle phase as the requirements define it
    int ph_m;
    always @(posedge clk) begin
        if (rst) ph_m <= 0;
        else     ph_m <= (ph_m == NPH - 1) ? 0 : ph_m + 1;
    end

    int vectors = 0;
    int miscompares = 0;
    int hold_cnt = 0;
    int acc_mem = 0;
    int n_xfers = 0;
    bit done = 0;
    exp_t q[$];
    logic [DW-1:0] shadow [256];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic expect_wr(input int d, input logic [AW-1:0] a, input logic [DW-1:0] w);
        exp_t e;
        e.dev = d; e.wr = 1'b1; e.addr = a; e.data = w;
        q.push_back(e);
        shadow[a[7:0]] = w;
        n_xfers++;
    endtask

    task automatic expect_rd(input int d, input logic [AW-1:0] a);
        exp_t e;
        e.dev = d; e.wr = 1'b0; e.addr = a; e.data = shadow[a[7:0]];
        q.push_back(e);
        n_xfers++;
    endtask

    // monitor: compares strobes with the scoreboard
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (cpu_hold) hold_cnt++;
            acc_mem += int'(mem_we) + int'(mem_re);
            if (|aack) begin
                chk($onehot(aack), "R3", "address ack one-hot", 32'(aack), 32'h1);
                chk(ph_m == 0, "R3", "address ack phase", 32'(ph_m), 32'h0);
            end
            if (|(dack | drdy)) begin
                chk(ph_m == MID + 1, "R4", "data strobe phase", 32'(ph_m), 32'(MID + 1));
                chk(acc_mem == 1, "R6", "memory accesses per cycle", 32'(acc_mem), 32'h1);
                acc_mem = 0;
                if (q.size() == 0) begin
                    chk(1'b0, "R7", "unexpected strobe", 32'({dack, drdy}), 32'h0);
                end else begin
                    exp_t e;
                    logic [NDEV-1:0] oh;
                    e  = q.pop_front();
                    oh = NDEV'(1) << e.dev;
                    if (e.wr) begin
                        chk(dack == oh && drdy == '0, "R7", "write served device", 32'(dack), 32'(oh));
                        chk(ram[e.addr[7:0]] == e.data, "R4", "memory after write",
                            32'(ram[e.addr[7:0]]), 32'(e.data));
                    end else begin
                        chk(drdy == oh && dack == '0, "R7", "read served device", 32'(drdy), 32'(oh));
                        chk(brk_rdata == e.data, "R5", "read word", 32'(brk_rdata), 32'(e.data));
                    end
                end
            end
        end
    end

    task automatic dev_xfer(input int d, input bit wr, input logic [AW-1:0] a,
                            input logic [DW-1:0] w, input bit pulse);
        @(negedge clk);
        t_req[d] = 1'b1;
        t_dir[d] = wr;
        t_addr[d*AW +: AW] = a;
        t_wdata[d*DW +: DW] = w;
        if (pulse) begin
            @(negedge clk);
            t_req[d] = 1'b0;
        end
        do @(negedge clk); while (!aack[d]);
        t_req[d] = 1'b0;
        t_addr[d*AW +: AW] = '1;   // R3: moving the address after the ack is harmless
        t_dir[d] = ~wr;
        do @(negedge clk); while (!(dack[d] || drdy[d]));
        t_wdata[d*DW +: DW] = ~w;
    endtask

    task automatic idle_check(input string tag);
        chk(aack == '0 && dack == '0 && drdy == '0, tag, "strobes idle", 32'({aack, dack, drdy}), 32'h0);
        chk(!cpu_hold && !mem_we && !mem_re, tag, "hold/enables idle",
            32'({cpu_hold, mem_we, mem_re}), 32'h0);
        chk(brk_rdata == '0, tag, "read bus idle", 32'(brk_rdata), 32'h0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) shadow[i] = init_word(i);
        repeat (3) @(negedge clk);
        idle_check("R1");
        rst = 1'b0;
        @(negedge clk);
        idle_check("R1");

        // R4 R10: device 0 writes memory (dir = 1)
        expect_wr(0, 15'h005, 18'h2A5A5);
        dev_xfer(0, 1'b1, 15'h005, 18'h2A5A5, 1'b0);

        // R5 R10: device 2 reads it back (dir = 0)
        expect_rd(2, 15'h005);
        dev_xfer(2, 1'b0, 15'h005, 18'h0, 1'b0);
        repeat (6) @(negedge clk);
        chk(brk_rdata == 18'h2A5A5, "R5", "read word held", 32'(brk_rdata), 32'h2A5A5);

        // R5: preloaded word
        expect_rd(1, 15'h040);
        dev_xfer(1, 1'b0, 15'h040, 18'h0, 1'b0);

        // R8: one-clock request inside a cycle
        while (ph_m != 0) @(negedge clk);
        expect_wr(3, 15'h021, 18'h13579);
        dev_xfer(3, 1'b1, 15'h021, 18'h13579, 1'b1);

        // R7: three devices at once, device 1 first, then 2, then 3
        expect_wr(1, 15'h030, 18'h0BEEF);
        expect_rd(2, 15'h030);
        expect_wr(3, 15'h031, 18'h3C3C3);
        fork
            dev_xfer(3, 1'b1, 15'h031, 18'h3C3C3, 1'b0);
            dev_xfer(2, 1'b0, 15'h030, 18'h0, 1'b0);
            dev_xfer(1, 1'b1, 15'h030, 18'h0BEEF, 1'b0);
        join
        chk(shadow[8'h30] == 18'h0BEEF, "R7", "shadow order", 32'(shadow[8'h30]), 32'h0BEEF);

        // R9: held request served in consecutive cycles
        begin
            int c0;
            int c1;
            expect_rd(0, 15'h050);
            expect_rd(0, 15'h051);
            @(negedge clk);
            t_req[0] = 1'b1;
            t_dir[0] = 1'b0;
            t_addr[0 +: AW] = 15'h050;
            c0 = 0;
            do begin @(negedge clk); c0++; end while (!aack[0]);
            t_addr[0 +: AW] = 15'h051;
            c1 = 0;
            do begin @(negedge clk); c1++; end while (!aack[0]);
            t_req[0] = 1'b0;
            chk(c1 == NPH, "R9", "gap between grants", 32'(c1), 32'(NPH));
            repeat (NPH) @(negedge clk);
        end

        repeat (3 * NPH) @(negedge clk);
        chk(q.size() == 0, "R2", "scoreboard drained", 32'(q.size()), 32'h0);
        chk(hold_cnt == NPH * n_xfers, "R2", "stolen clocks", 32'(hold_cnt), 32'(NPH * n_xfers));
        chk(!cpu_hold, "R2", "hold released", 32'(cpu_hold), 32'h0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule